// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Integer Pipeline

This block decides, every cycle, where each operand of the instruction now in the execute stage comes from. It compares the two source register numbers of that instruction with the destination registers recorded in the two pipeline registers behind the ALU, one after execute and one after memory access. From that comparison it drives the select lines of the two ALU input multiplexers. The value comes from the register file, from the ALU result just produced, or from the value about to be written back.

The block also drives a store-data multiplexer. When the store now in the memory stage writes a register that the load just ahead of it has fetched, the load's data goes straight into the data-memory write port, so the pair runs without a stall. The block is purely combinational. Stall generation, the register file and the datapath multiplexers themselves sit outside it.

Registers are written only in the writeback stage and read only in decode, and the register file writes before it reads within a cycle. As a result the block handles only read-after-write dependences of one and two instructions.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory stage writes a nonzero register equal to a source, and is not a load, that operand's select is 2'b10.
- R2: When only the memory/writeback stage writes a nonzero register equal to a source, that operand's select is 2'b01.
- R3: When both later stages match the same source and neither blocks it, the execute/memory stage wins and the select is 2'b10.
- R4: A destination of register 0 never causes forwarding, and the select stays 2'b00.
- R5: A stage whose register-write enable is low never causes forwarding.
- R6: When the execute/memory stage is a load that writes the source register, the select is 2'b00, even if the memory/writeback stage also matches. The resulting stall is handled elsewhere.
- R7: Operand A follows the rs source and operand B follows the rt source, each decided on its own.
- R8: The store-data select is 1 exactly when the memory/writeback stage is a load with write enable high, its destination is nonzero, the memory stage holds a store, and the store's data register equals that destination.
- R9: The store-data select is 0 when any condition of R8 is missing.
- R10: An operand select never takes the value 2'b11.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register of the instruction in execute |
| ex_rt | input | 5 | Second source register of the instruction in execute |
| exm_rd | input | 5 | Destination register held in the execute/memory register |
| exm_we | input | 1 | Register write enable in the execute/memory register |
| exm_load | input | 1 | Execute/memory instruction is a load (memory to register) |
| exm_store | input | 1 | Execute/memory instruction is a store |
| exm_rt | input | 5 | Data register of the store in the execute/memory register |
| mwb_rd | input | 5 | Destination register held in the memory/writeback register |
| mwb_we | input | 1 | Register write enable in the memory/writeback register |
| mwb_load | input | 1 | Memory/writeback instruction is a load |
| sel_a | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B select, same encoding |
| sel_st | output | 1 | Store data select: 1 takes the load data from memory/writeback |

## Verification
Several properties are checked by the assertions on every input combination the bench applies. Register 0 and disabled writes must never raise a select, and a matching load ahead must block its operand. A raised store select must come with a load, a store and equal registers, and the unused code 11 must never appear. Only the bench's scenarios can show that a younger match wins over an older one with the exact code, that the two operands are decided separately, and that each single missing condition drops the store select.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int REG_AW = 5;
    localparam int SEL_W  = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF    = 2'b00,
        SRC_MEMWB = 2'b01,
        SRC_EXMEM = 2'b10
    } op_src_e;

    typedef struct packed {
        reg_idx_t rd;
        logic     we;
        logic     load;
    } stage_dst_t;

    function automatic logic dst_live(input stage_dst_t d);
        return d.we && (d.rd != '0);
    endfunction
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit
    import fwd_pkg::*;
(
    input  stage_dst_t dst,
    input  reg_idx_t   src,
    output logic       hit
);
    always_comb hit = dst_live(dst) && (dst.rd == src);
endmodule

// File: rtl/fwd_opsel.sv
module fwd_opsel
    import fwd_pkg::*;
(
    input  reg_idx_t   src,
    input  stage_dst_t exm,
    input  stage_dst_t mwb,
    output op_src_e    sel
);
    logic hit_exm;
    logic hit_mwb;

    fwd_hit u_hit_exm (.dst(exm), .src(src), .hit(hit_exm));
    fwd_hit u_hit_mwb (.dst(mwb), .src(src), .hit(hit_mwb));

    // younger stage first; a matching load ahead hides the older value
    always_comb begin
        if (hit_exm) sel = exm.load ? SRC_RF : SRC_EXMEM;
        else if (hit_mwb) sel = SRC_MEMWB;
        else sel = SRC_RF;
    end
endmodule

// File: rtl/fwd_stsel.sv
module fwd_stsel
    import fwd_pkg::*;
(
    input  stage_dst_t mwb,
    input  logic       st_valid,
    input  reg_idx_t   st_rt,
    output logic       sel
);
    logic hit;

    fwd_hit u_hit (.dst(mwb), .src(st_rt), .hit(hit));

    always_comb sel = hit && mwb.load && st_valid;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int NUM_OPS = 2
) (
    input  logic [4:0] ex_rs,
    input  logic [4:0] ex_rt,
    input  logic [4:0] exm_rd,
    input  logic       exm_we,
    input  logic       exm_load,
    input  logic       exm_store,
    input  logic [4:0] exm_rt,
    input  logic [4:0] mwb_rd,
    input  logic       mwb_we,
    input  logic       mwb_load,
    output logic [1:0] sel_a,
    output logic [1:0] sel_b,
    output logic       sel_st
);
    stage_dst_t exm_d;
    stage_dst_t mwb_d;
    reg_idx_t   srcs [NUM_OPS];
    op_src_e    sels [NUM_OPS];

    always_comb begin
        exm_d = '{rd: exm_rd, we: exm_we, load: exm_load};
        mwb_d = '{rd: mwb_rd, we: mwb_we, load: mwb_load};
        srcs[0] = ex_rs;
        srcs[1] = ex_rt;
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        fwd_opsel u_opsel (
            .src (srcs[i]),
            .exm (exm_d),
            .mwb (mwb_d),
            .sel (sels[i])
        );
    end

    fwd_stsel u_stsel (
        .mwb      (mwb_d),
        .st_valid (exm_store),
        .st_rt    (exm_rt),
        .sel      (sel_st)
    );

    assign sel_a = sels[0];
    assign sel_b = sels[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk (
    input logic [4:0] ex_rs,
    input logic [4:0] ex_rt,
    input logic [4:0] exm_rd,
    input logic       exm_we,
    input logic       exm_load,
    input logic       exm_store,
    input logic [4:0] exm_rt,
    input logic [4:0] mwb_rd,
    input logic       mwb_we,
    input logic       mwb_load,
    input logic [1:0] sel_a,
    input logic [1:0] sel_b,
    input logic       sel_st
);
    always_comb begin
        a_r10_no_code3: assert (sel_a != 2'b11 && sel_b != 2'b11)
            else $error("R10 select code 11 seen");
        a_r4_zero_src_a: assert (ex_rs != 5'd0 || sel_a == 2'b00)
            else $error("R4 forward on register 0 (A)");
        a_r4_zero_src_b: assert (ex_rt != 5'd0 || sel_b == 2'b00)
            else $error("R4 forward on register 0 (B)");
        a_r5_we_gate: assert (exm_we || mwb_we || (sel_a == 2'b00 && sel_b == 2'b00 && !sel_st))
            else $error("R5 forward with writes disabled");
        a_r6_load_block: assert (!(exm_we && exm_load && exm_rd == ex_rs) || sel_a == 2'b00)
            else $error("R6 forward past a load");
        a_r8_st_cause: assert (!sel_st || (mwb_load && mwb_we && exm_store
                                           && exm_rt == mwb_rd && mwb_rd != 5'd0))
            else $error("R8 store select without cause");
    end
endmodule

bind fwd_unit fwd_unit_chk u_chk (.*);

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0] ex_rs, ex_rt, exm_rd, exm_rt, mwb_rd;
    logic       exm_we, exm_load, exm_store, mwb_we, mwb_load;
    logic [1:0] sel_a, sel_b;
    logic       sel_st;

    fwd_unit dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct packed {
        logic [4:0] rs, rt, erd;
        logic       ewe, eld, est;
        logic [4:0] ert, wrd;
        logic       wwe, wld;
        logic [1:0] xa, xb;
        logic       xs;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        // R1 one-back ALU result on A
        '{5'd2, 5'd5, 5'd2, 1, 0, 0, 5'd0, 5'd0, 0, 0, 2'b10, 2'b00, 0},
        // R1 one-back on B
        '{5'd6, 5'd2, 5'd2, 1, 0, 0, 5'd0, 5'd0, 0, 0, 2'b00, 2'b10, 0},
        // R2 two-back on both
        '{5'd2, 5'd2, 5'd9, 1, 0, 0, 5'd0, 5'd2, 1, 0, 2'b01, 2'b01, 0},
        // R3 both match, younger wins
        '{5'd4, 5'd7, 5'd4, 1, 0, 0, 5'd0, 5'd4, 1, 0, 2'b10, 2'b00, 0},
        // R4 register 0
        '{5'd0, 5'd0, 5'd0, 1, 0, 0, 5'd0, 5'd0, 1, 0, 2'b00, 2'b00, 0},
        // R5 enables low
        '{5'd3, 5'd8, 5'd3, 0, 0, 0, 5'd0, 5'd8, 0, 0, 2'b00, 2'b00, 0},
        // R6 load ahead blocks, older match ignored
        '{5'd11, 5'd1, 5'd11, 1, 1, 0, 5'd0, 5'd11, 1, 0, 2'b00, 2'b00, 0},
        // R7 A from EX/MEM, B from MEM/WB
        '{5'd12, 5'd13, 5'd12, 1, 0, 0, 5'd0, 5'd13, 1, 0, 2'b10, 2'b01, 0},
        // R8 load then store of loaded reg
        '{5'd1, 5'd2, 5'd0, 0, 0, 1, 5'd16, 5'd16, 1, 1, 2'b00, 2'b00, 1},
        // R9 MEM/WB not a load
        '{5'd1, 5'd2, 5'd0, 0, 0, 1, 5'd16, 5'd16, 1, 0, 2'b00, 2'b00, 0},
        // R9 no store in memory stage
        '{5'd1, 5'd2, 5'd0, 0, 0, 0, 5'd16, 5'd16, 1, 1, 2'b00, 2'b00, 0},
        // R9 register mismatch
        '{5'd1, 5'd2, 5'd0, 0, 0, 1, 5'd17, 5'd16, 1, 1, 2'b00, 2'b00, 0}
    };

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        ex_rs = v.rs; ex_rt = v.rt; exm_rd = v.erd; exm_we = v.ewe;
        exm_load = v.eld; exm_store = v.est; exm_rt = v.ert;
        mwb_rd = v.wrd; mwb_we = v.wwe; mwb_load = v.wld;
        @(negedge clk);
    endtask

    initial begin
        apply('0);
        chk("R5 idle state", {sel_a, sel_b, sel_st}, 5'b00000);

        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            chk($sformatf("vector %0d", i), {sel_a, sel_b, sel_st},
                {VT[i].xa, VT[i].xb, VT[i].xs});
        end

        // R8 store select with destination 0 must stay low (R9)
        apply('{5'd1, 5'd2, 5'd0, 0, 0, 1, 5'd0, 5'd0, 1, 1, 2'b00, 2'b00, 0});
        chk("R9 load to r0", {4'b0, sel_st}, 5'b0);
        // R6 load ahead on B only, A still forwarded from MEM/WB
        apply('{5'd9, 5'd10, 5'd10, 1, 1, 0, 5'd0, 5'd9, 1, 0, 2'b01, 2'b00, 0});
        chk("R6 load on B, R2 on A", {sel_a, sel_b, 1'b0}, 5'b01000);
        // R10 sweep: every rs/rt pair for a double match stays legal
        for (int r = 0; r < 32; r++) begin
            apply('{r[4:0], r[4:0], r[4:0], 1, 0, 0, 5'd0, r[4:0], 1, 0, 2'b00, 2'b00, 0});
            chk("R10/R3 sweep", {3'b0, sel_a}, (r == 0) ? 5'b0 : 5'b00010);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule